// File: doc/BRIEF.md
# Line-Termination Activation Command Controller

This block sequences activation and deactivation of a two-binary-one-quaternary ISDN line at its line-termination end. Each cycle the system side may present a 4-bit command with a valid strobe. The block combines these commands with line status: wake-up tone seen, superframe lock, the received act and sai bits, loss of signal and loss of sync. From them it selects which start-up signal the transmitter sends: nothing, the wake tone, the first synchronizing signal (SL1), or the framed signal (SL2/SL3). It also drives the transmitted uoa and act bits, a full loopback enable, a single-pulse test mode and a power-down request.

Status goes back to the system side as 4-bit indication codes. A code is presented only when it differs from the last one, and a one-cycle valid pulse marks it. An activation timer counts an external tick, and a failed start-up returns the block to the deactivated state with an error indication. A U-only activation keeps uoa at zero so that the far subscriber bus stays down. The activation-indicate command takes effect only when a bypass configuration bit is set or the automatic repeater mode is selected.

Top module: `lt_act_ctrl`

## Requirements
- R1: After synchronous reset the block is powered up and deactivated. tx_sig is 0, tx_uoa, tx_act, loop_en, pulse_test, pwr_down and ind_valid are all 0, and ind_code is 1111.
- R2: Command 1000 in the deactivated or powered-down state sends the wake tone (tx_sig=1) for TL_LEN cycles, then SL1 (tx_sig=2) until sf_sync is 1, then SL2/SL3 (tx_sig=3). tx_uoa is 1 throughout.
- R3: Command 0110 runs the same start-up with tx_uoa=0. On an active line, 0110 clears tx_uoa and 1000 sets it, and neither changes tx_sig.
- R4: Command 1010 starts up like 1000 and also sets loop_en. Command 0000 returns any active or test state to deactivated and clears every line output. If loop_en was 1 when 0000 arrived, the next 1010 is a warm start that goes straight to SL1.
- R5: Command 1011 in the deactivated state enters the pulse test: pulse_test=1 and tx_sig=0 until command 0000.
- R6: Command 1100 sets tx_act only when cfg_ai_bypass or cfg_auto_rpt is 1 and the line is in SL2/SL3 with rx_act=1. In any other case it has no effect.
- R7: Command 1111 in the deactivated state causes two consecutive ind_valid pulses carrying 1111, with pwr_down rising together with the second pulse. In any other state 1111 is ignored.
- R8: Any of the following returns the line to deactivated, clears the line outputs, reports indication 0001 and forces the next activation to be a cold start: sig_lost in an active state, sync_lost in SL2/SL3, TMO_TICKS ticks counted during wake tone and SL1, or reset command 0001 in any state.
- R9: In SL2/SL3 the indication is 1100 when rx_act=1. It is 0100 when rx_act has returned to 0 after being 1. Otherwise it is 0110.
- R10: Indication 1000 reports wake_tone when deactivated with no pending error. In SL2/SL3 with tx_uoa=0 it instead reports rx_sai=1.
- R11: ind_code and ind_valid update one cycle after their cause. ind_valid is high for one cycle only when the code changes, with the power-down repeat of R7 as the only exception.
- R12: Codes 0010, 0011, 0100, 0101, 0111, 1001, 1101 and 1110 are ignored, and so is any code presented while cmd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| cfg_ai_bypass | input | 1 | Allows the activation-indicate command |
| cfg_auto_rpt | input | 1 | Automatic repeater mode selected |
| tick | input | 1 | Activation timer time base |
| wake_tone | input | 1 | Wake-up tone detected on the line |
| sf_sync | input | 1 | Superframe synchronized |
| rx_act | input | 1 | Received act bit |
| rx_sai | input | 1 | Received sai bit |
| sig_lost | input | 1 | Loss of signal |
| sync_lost | input | 1 | Loss of superframe sync |
| tx_sig | output | 2 | Transmit signal: 0 none, 1 wake tone, 2 SL1, 3 SL2/SL3 |
| tx_uoa | output | 1 | Transmitted uoa bit |
| tx_act | output | 1 | Transmitted act bit |
| loop_en | output | 1 | Full transmit-to-receive loopback |
| pulse_test | output | 1 | Single +3/-3 pulse per frame test |
| pwr_down | output | 1 | Power-down request |
| ind_valid | output | 1 | Indication strobe |
| ind_code | output | 4 | Indication code |

## Verification
The bench builds the block with TL_LEN=4 and TMO_TICKS=6. The short wake tone lets every start-up reach SL2/SL3 in a handful of cycles. The six-tick timeout makes the timer-expiry abort, and the cold start that follows it, reachable by pulsing tick a few times. With these settings the warm-start path, the power-down double indication and the U-only uoa toggling all fit in one short sequence, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/lt_act_pkg.sv
package lt_act_pkg;

    typedef enum logic [3:0] {
        CMD_DEACT_REQ = 4'b0000,
        CMD_RESET     = 4'b0001,
        CMD_UONLY_ACT = 4'b0110,
        CMD_ACT       = 4'b1000,
        CMD_ACT_LOOP  = 4'b1010,
        CMD_PULSE     = 4'b1011,
        CMD_ACT_IND   = 4'b1100,
        CMD_PDOWN     = 4'b1111
    } cmd_e;

    typedef enum logic [3:0] {
        IND_ERR      = 4'b0001,
        IND_ACT_LOST = 4'b0100,
        IND_SYNC     = 4'b0110,
        IND_PEND     = 4'b1000,
        IND_ACTIVE   = 4'b1100,
        IND_DEACT    = 4'b1111
    } ind_e;

    typedef enum logic [1:0] {
        TX_NONE = 2'd0,
        TX_TONE = 2'd1,
        TX_SL1  = 2'd2,
        TX_SL23 = 2'd3
    } tx_e;

    typedef enum logic [2:0] {
        S_PDN,
        S_IDLE,
        S_TONE,
        S_SL1,
        S_SYNC,
        S_PULSE,
        S_PDPREP
    } lt_state_e;

    typedef struct packed {
        logic deact;
        logic reset;
        logic uonly;
        logic act;
        logic act_loop;
        logic pulse;
        logic act_ind;
        logic pdown;
    } cmd_req_t;

    typedef struct packed {
        logic uoa;
        logic act;
        logic loop;
        logic warm;
        logic err;
        logic seen;
    } ctl_t;

    function automatic logic [1:0] tx_of_state(lt_state_e s);
        case (s)
            S_TONE:  return TX_TONE;
            S_SL1:   return TX_SL1;
            S_SYNC:  return TX_SL23;
            default: return TX_NONE;
        endcase
    endfunction

    function automatic logic is_line_active(lt_state_e s);
        return (s == S_TONE) || (s == S_SL1) || (s == S_SYNC);
    endfunction

endpackage

// File: rtl/lt_act_cmd_dec.sv
module lt_act_cmd_dec
    import lt_act_pkg::*;
(
    input  logic       valid,
    input  logic [3:0] code,
    input  logic       ai_bypass,
    input  logic       auto_rpt,
    output cmd_req_t   req
);
    always_comb begin
        req          = '0;
        req.deact    = valid && (code == CMD_DEACT_REQ);
        req.reset    = valid && (code == CMD_RESET);
        req.uonly    = valid && (code == CMD_UONLY_ACT);
        req.act      = valid && (code == CMD_ACT);
        req.act_loop = valid && (code == CMD_ACT_LOOP);
        req.pulse    = valid && (code == CMD_PULSE);
        req.act_ind  = valid && (code == CMD_ACT_IND) && (ai_bypass || auto_rpt);
        req.pdown    = valid && (code == CMD_PDOWN);
    end
endmodule

// File: rtl/lt_act_timer.sv
module lt_act_timer #(
    parameter int LIMIT = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && (cnt != LIM)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LIM);
endmodule

// File: rtl/lt_act_ind.sv
module lt_act_ind
    import lt_act_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] want,
    input  logic       force_rep,
    output logic [3:0] code,
    output logic       valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= IND_DEACT;
            valid <= 1'b0;
        end else if (force_rep) begin
            code  <= IND_DEACT;
            valid <= 1'b1;
        end else begin
            valid <= (want != code);
            code  <= want;
        end
    end
endmodule

// File: rtl/lt_act_ctrl.sv
module lt_act_ctrl
    import lt_act_pkg::*;
#(
    parameter int TL_LEN    = 1024,
    parameter int TMO_TICKS = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_code,
    input  logic       cfg_ai_bypass,
    input  logic       cfg_auto_rpt,
    input  logic       tick,
    input  logic       wake_tone,
    input  logic       sf_sync,
    input  logic       rx_act,
    input  logic       rx_sai,
    input  logic       sig_lost,
    input  logic       sync_lost,
    output logic [1:0] tx_sig,
    output logic       tx_uoa,
    output logic       tx_act,
    output logic       loop_en,
    output logic       pulse_test,
    output logic       pwr_down,
    output logic       ind_valid,
    output logic [3:0] ind_code
);
    localparam int TLW = (TL_LEN > 1) ? $clog2(TL_LEN) : 1;
    localparam logic [TLW-1:0] TL_LAST = TLW'(TL_LEN - 1);

    lt_state_e      st, st_n;
    ctl_t           ctl, ctl_n;
    logic [TLW-1:0] tl, tl_n;
    logic           pd, pd_n;
    cmd_req_t       req;
    logic           tmr_exp;
    logic           abort;
    logic           start;
    logic [3:0]     want;

    lt_act_cmd_dec u_dec (
        .valid     (cmd_valid),
        .code      (cmd_code),
        .ai_bypass (cfg_ai_bypass),
        .auto_rpt  (cfg_auto_rpt),
        .req       (req)
    );

    lt_act_timer #(.LIMIT(TMO_TICKS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     ((st == S_TONE) || (st == S_SL1)),
        .tick    (tick),
        .expired (tmr_exp)
    );

    // Indication wanted for the present state and line status
    always_comb begin
        case (st)
            S_IDLE: begin
                if (ctl.err)        want = IND_ERR;
                else if (wake_tone) want = IND_PEND;
                else                want = IND_DEACT;
            end
            S_TONE, S_SL1: want = ind_code;
            S_SYNC: begin
                if (!ctl.uoa && rx_sai) want = IND_PEND;
                else if (rx_act)        want = IND_ACTIVE;
                else if (ctl.seen)      want = IND_ACT_LOST;
                else                    want = IND_SYNC;
            end
            default: want = IND_DEACT;
        endcase
    end

    lt_act_ind u_ind (
        .clk       (clk),
        .rst       (rst),
        .want      (want),
        .force_rep (st == S_PDPREP),
        .code      (ind_code),
        .valid     (ind_valid)
    );

    assign abort = is_line_active(st) &&
                   (sig_lost || tmr_exp || ((st == S_SYNC) && sync_lost));
    assign start = req.uonly || req.act || req.act_loop;

    always_comb begin
        st_n     = st;
        ctl_n    = ctl;
        tl_n     = tl;
        pd_n     = pd;
        ctl_n.seen = (st == S_SYNC) ? (ctl.seen || rx_act) : 1'b0;
        if (req.reset || abort) begin
            st_n       = S_IDLE;
            ctl_n.uoa  = 1'b0;
            ctl_n.act  = 1'b0;
            ctl_n.loop = 1'b0;
            ctl_n.warm = 1'b0;
            ctl_n.err  = 1'b1;
        end else begin
            case (st)
                S_PDN, S_IDLE: begin
                    if (start) begin
                        st_n       = (req.act_loop && ctl.warm) ? S_SL1 : S_TONE;
                        tl_n       = '0;
                        ctl_n.uoa  = !req.uonly;
                        ctl_n.loop = req.act_loop;
                        ctl_n.act  = 1'b0;
                        ctl_n.warm = 1'b0;
                        ctl_n.err  = 1'b0;
                    end else if ((st == S_IDLE) && req.pulse) begin
                        st_n = S_PULSE;
                    end else if ((st == S_IDLE) && req.pdown) begin
                        st_n      = S_PDPREP;
                        pd_n      = 1'b0;
                        ctl_n.err = 1'b0;
                    end
                end
                S_TONE, S_SL1, S_SYNC: begin
                    if (st == S_TONE) begin
                        if (tl == TL_LAST) st_n = S_SL1;
                        else               tl_n = tl + 1'b1;
                    end
                    if ((st == S_SL1) && sf_sync) st_n = S_SYNC;
                    if (req.uonly) ctl_n.uoa = 1'b0;
                    if (req.act)   ctl_n.uoa = 1'b1;
                    if (req.act_ind && (st == S_SYNC) && rx_act) ctl_n.act = 1'b1;
                    if (req.deact) begin
                        st_n       = S_IDLE;
                        ctl_n.uoa  = 1'b0;
                        ctl_n.act  = 1'b0;
                        ctl_n.loop = 1'b0;
                        ctl_n.warm = ctl.loop;
                        ctl_n.err  = 1'b0;
                    end
                end
                S_PULSE: begin
                    if (req.deact) st_n = S_IDLE;
                end
                S_PDPREP: begin
                    if (pd) st_n = S_PDN;
                    else    pd_n = 1'b1;
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            ctl <= '0;
            tl  <= '0;
            pd  <= 1'b0;
        end else begin
            st  <= st_n;
            ctl <= ctl_n;
            tl  <= tl_n;
            pd  <= pd_n;
        end
    end

    assign tx_sig     = tx_of_state(st);
    assign tx_uoa     = ctl.uoa;
    assign tx_act     = ctl.act;
    assign loop_en    = ctl.loop;
    assign pulse_test = (st == S_PULSE);
    assign pwr_down   = (st == S_PDN);
endmodule

// File: rtl/lt_act_ctrl_chk.sv
module lt_act_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [3:0] cmd_code,
    input logic       rx_act,
    input logic       sig_lost,
    input logic [1:0] tx_sig,
    input logic       tx_uoa,
    input logic       tx_act,
    input logic       loop_en,
    input logic       pulse_test,
    input logic       pwr_down,
    input logic       ind_valid,
    input logic [3:0] ind_code
);
    // R7
    pd_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_down) |-> ind_valid && $past(ind_valid) && (ind_code == 4'hF));

    // R5
    pulse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_test |-> (tx_sig == 2'd0) && !pwr_down);

    // R2
    sl23_order_chk: assert property (@(posedge clk) disable iff (rst)
        ((tx_sig == 2'd3) && ($past(tx_sig) != 2'd3)) |-> ($past(tx_sig) == 2'd2));

    // R6
    act_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_act) |-> (tx_sig == 2'd3) && $past(rx_act) && $past(cmd_valid)
                          && ($past(cmd_code) == 4'hC));

    // R8
    los_abort_chk: assert property (@(posedge clk) disable iff (rst)
        ((tx_sig != 2'd0) && sig_lost) |=> (tx_sig == 2'd0) && !tx_uoa && !loop_en);

    // R11
    ind_change_chk: assert property (@(posedge clk) disable iff (rst)
        (ind_valid && (ind_code != 4'hF)) |-> (ind_code != $past(ind_code)));
endmodule

bind lt_act_ctrl lt_act_ctrl_chk chk_i (.*);

// File: tb/lt_act_ctrl_tb_top.sv
module lt_act_ctrl_tb_top;
    localparam int TLL = 4;
    localparam int TMO = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'h0;
    logic cfg_ai_bypass = 1'b0, cfg_auto_rpt = 1'b0, tick = 1'b0;
    logic wake_tone = 1'b0, sf_sync = 1'b0, rx_act = 1'b0, rx_sai = 1'b0;
    logic sig_lost = 1'b0, sync_lost = 1'b0;
    logic [1:0] tx_sig;
    logic tx_uoa, tx_act, loop_en, pulse_test, pwr_down, ind_valid;
    logic [3:0] ind_code;

    always #10 clk = ~clk;

    lt_act_ctrl #(.TL_LEN(TLL), .TMO_TICKS(TMO)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cfg_ai_bypass(cfg_ai_bypass), .cfg_auto_rpt(cfg_auto_rpt), .tick(tick),
        .wake_tone(wake_tone), .sf_sync(sf_sync), .rx_act(rx_act), .rx_sai(rx_sai),
        .sig_lost(sig_lost), .sync_lost(sync_lost), .tx_sig(tx_sig), .tx_uoa(tx_uoa),
        .tx_act(tx_act), .loop_en(loop_en), .pulse_test(pulse_test),
        .pwr_down(pwr_down), .ind_valid(ind_valid), .ind_code(ind_code)
    );

    int total = 0;
    int fails = 0;
    bit done = 0;
    string cur = "R1";

    // model state: 0 pdn, 1 idle, 2 tone, 3 sl1, 4 sync, 5 pulse, 6 pd prep
    int m_st = 1, m_tl = 0, m_tmr = 0, m_pd = 0, m_code = 15, m_val = 0;
    int m_uoa = 0, m_act = 0, m_loop = 0, m_warm = 0, m_err = 0, m_seen = 0;

    task automatic chk(string req, int act, int exp, string what);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        int want, st, n_tl, n_pd, n_uoa, n_act, n_loop, n_warm, n_err;
        bit v, run, expd, strt;
        v = cmd_valid;
        st = m_st; n_tl = m_tl; n_pd = m_pd; n_uoa = m_uoa; n_act = m_act;
        n_loop = m_loop; n_warm = m_warm; n_err = m_err;
        case (m_st)
            1: want = m_err ? 1 : (wake_tone ? 8 : 15);
            2, 3: want = m_code;
            4: want = (!m_uoa && rx_sai) ? 8 : (rx_act ? 12 : (m_seen ? 4 : 6));
            default: want = 15;
        endcase
        run = (m_st == 2) || (m_st == 3);
        expd = run && (m_tmr == TMO);
        strt = v && (cmd_code == 4'h6 || cmd_code == 4'h8 || cmd_code == 4'hA);
        if ((v && cmd_code == 4'h1) ||
            ((m_st >= 2 && m_st <= 4) && (sig_lost || expd || (m_st == 4 && sync_lost)))) begin
            st = 1; n_uoa = 0; n_act = 0; n_loop = 0; n_warm = 0; n_err = 1;
        end else if (m_st <= 1) begin
            if (strt) begin
                st = (cmd_code == 4'hA && m_warm != 0) ? 3 : 2;
                n_tl = 0; n_uoa = (cmd_code != 4'h6); n_loop = (cmd_code == 4'hA);
                n_act = 0; n_warm = 0; n_err = 0;
            end else if (m_st == 1 && v && cmd_code == 4'hB) st = 5;
            else if (m_st == 1 && v && cmd_code == 4'hF) begin st = 6; n_pd = 0; n_err = 0; end
        end else if (m_st <= 4) begin
            if (m_st == 2) begin if (m_tl == TLL - 1) st = 3; else n_tl = m_tl + 1; end
            if (m_st == 3 && sf_sync) st = 4;
            if (v && cmd_code == 4'h6) n_uoa = 0;
            if (v && cmd_code == 4'h8) n_uoa = 1;
            if (v && cmd_code == 4'hC && (cfg_ai_bypass || cfg_auto_rpt) && m_st == 4 && rx_act)
                n_act = 1;
            if (v && cmd_code == 4'h0) begin
                st = 1; n_uoa = 0; n_act = 0; n_warm = m_loop; n_loop = 0; n_err = 0;
            end
        end else if (m_st == 5) begin
            if (v && cmd_code == 4'h0) st = 1;
        end else begin
            if (m_pd != 0) st = 0; else n_pd = 1;
        end
        if (m_st == 6) begin m_code = 15; m_val = 1; end
        else begin m_val = (want != m_code); m_code = want; end
        if (!run) m_tmr = 0; else if (tick && m_tmr != TMO) m_tmr++;
        m_seen = (m_st == 4) ? (m_seen | rx_act) : 0;
        m_st = st; m_tl = n_tl; m_pd = n_pd; m_uoa = n_uoa; m_act = n_act;
        m_loop = n_loop; m_warm = n_warm; m_err = n_err;
    endtask

    task automatic compare();
        int tx;
        tx = (m_st == 2) ? 1 : (m_st == 3) ? 2 : (m_st == 4) ? 3 : 0;
        chk(cur, tx_sig, tx, "tx_sig");
        chk(cur, tx_uoa, m_uoa, "tx_uoa");
        chk(cur, tx_act, m_act, "tx_act");
        chk(cur, loop_en, m_loop, "loop_en");
        chk(cur, pulse_test, m_st == 5, "pulse_test");
        chk(cur, pwr_down, m_st == 0, "pwr_down");
        chk(cur, ind_valid, m_val, "ind_valid");
        chk(cur, ind_code, m_code, "ind_code");
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic cmd(logic [3:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        cyc();
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur = "R1";
        compare();
        chk("R1", tx_sig, 0, "reset tx_sig");
        chk("R1", ind_code, 15, "reset ind_code");
        chk("R1", ind_valid, 0, "reset ind_valid");
        chk("R1", pwr_down, 0, "reset pwr_down");
        cyc(2);

        cur = "R10";
        wake_tone = 1; cyc();
        chk("R10", ind_code, 8, "wake indication");
        chk("R11", ind_valid, 1, "pulse on change");
        cur = "R11"; cyc();
        chk("R11", ind_valid, 0, "single pulse");
        wake_tone = 0; cyc(2);

        cur = "R2";
        cmd(4'h8);
        chk("R2", tx_sig, 1, "tone start");
        chk("R2", tx_uoa, 1, "uoa set");
        cyc(3);
        chk("R2", tx_sig, 1, "tone length");
        cyc();
        chk("R2", tx_sig, 2, "sl1 after tone");
        cyc(2);
        sf_sync = 1; cyc();
        chk("R2", tx_sig, 3, "sl23 on sync");
        cur = "R9"; cyc();
        chk("R9", ind_code, 6, "sync indication");
        rx_act = 1; cyc();
        chk("R9", ind_code, 12, "active indication");
        cur = "R6";
        cmd(4'hC);
        chk("R6", tx_act, 0, "act ind gated off");
        cfg_ai_bypass = 1; cmd(4'hC);
        chk("R6", tx_act, 1, "act ind accepted");
        cfg_ai_bypass = 0;
        cur = "R9"; rx_act = 0; cyc();
        chk("R9", ind_code, 4, "act lost indication");
        cyc();

        cur = "R8";
        sync_lost = 1; cyc();
        chk("R8", tx_sig, 0, "sync loss abort");
        sync_lost = 0; sf_sync = 0; cyc();
        chk("R8", ind_code, 1, "error indication");

        cur = "R3";
        cmd(4'h6);
        chk("R3", tx_uoa, 0, "u-only uoa");
        cyc(5); sf_sync = 1; cyc(2);
        chk("R3", tx_sig, 3, "u-only sync");
        cur = "R10"; rx_sai = 1; cyc(2);
        chk("R10", ind_code, 8, "sai indication");
        cur = "R3"; cmd(4'h8);
        chk("R3", tx_uoa, 1, "uoa raised");
        chk("R3", tx_sig, 3, "line kept");
        cmd(4'h6);
        chk("R3", tx_uoa, 0, "uoa dropped");
        rx_sai = 0; cyc();
        cur = "R8"; sig_lost = 1; cyc();
        chk("R8", tx_sig, 0, "signal loss abort");
        sig_lost = 0; sf_sync = 0; cyc(2);

        cur = "R12";
        cmd_code = 4'h8; cyc(2);
        chk("R12", tx_sig, 0, "no strobe ignored");
        cmd(4'h3); cmd(4'h5); cmd(4'hE);
        chk("R12", tx_sig, 0, "unknown ignored");
        chk("R12", ind_code, 1, "indication kept");

        cur = "R4";
        cmd(4'hA);
        chk("R4", tx_sig, 1, "loop cold start");
        chk("R4", loop_en, 1, "loop on");
        cyc(5); sf_sync = 1; cyc(2);
        chk("R4", tx_sig, 3, "loop sync");
        cmd(4'h0);
        chk("R4", tx_sig, 0, "deact request");
        chk("R4", loop_en, 0, "loop off");
        sf_sync = 0; cyc();
        cmd(4'hA);
        chk("R4", tx_sig, 2, "warm start");
        cmd(4'h0); cyc();
        cur = "R8";
        cmd(4'h1);
        cyc();
        chk("R8", ind_code, 1, "reset answer");
        cmd(4'hA);
        chk("R8", tx_sig, 1, "cold after error");
        for (int k = 0; k < TMO; k++) begin
            tick = 1; cyc(); tick = 0; cyc();
        end
        chk("R8", tx_sig, 0, "timer abort");
        cyc();
        chk("R8", ind_code, 1, "timer error indication");

        cur = "R5";
        cmd(4'hB);
        chk("R5", pulse_test, 1, "pulse test on");
        chk("R5", tx_sig, 0, "pulse no signal");
        cyc(2); cmd(4'h0);
        chk("R5", pulse_test, 0, "pulse test off");

        cur = "R7";
        cmd(4'h8);
        cmd(4'hF);
        chk("R7", pwr_down, 0, "pdown ignored when active");
        chk("R7", tx_sig, 1, "still active");
        cmd(4'h0); cyc(2);
        cmd(4'hF);
        cyc();
        chk("R7", ind_valid, 1, "first repeat");
        chk("R7", ind_code, 15, "first repeat code");
        cyc();
        chk("R7", ind_valid, 1, "second repeat");
        chk("R7", pwr_down, 1, "powered down");
        cyc(2);
        cmd(4'h8);
        chk("R2", tx_sig, 1, "start from power down");
        chk("R2", pwr_down, 0, "wake from power down");
        cmd(4'h1); cyc(2);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule